// File: doc/BRIEF.md
# Segment Limit and Rights Checker

This block vets one memory access against the cached attributes of a segment. It is meant for protected, non-64-bit operation. Each access arrives with an effective offset, a byte count, and a type: read, write or instruction fetch. It also carries the segment base, the segment limit and three attribute bits: writable, readable and grows-downward. One clock later the block reports whether the access is allowed or raises a general-protection fault. It echoes the caller's tag and the offset with that result.

The block does not check every access. With protection disabled (real mode), the offset passes straight through. It also passes through when the core runs in 64-bit mode, which means the long-mode-active bit and the code segment's long attribute are both set. In either case a bypass flag is raised and the fault is never set. All limit arithmetic is done one bit wider than an address, so offset plus size never wraps around.

Top module: `seg_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid and out_fault are 0.
- R2: out_valid equals in_valid of the previous cycle; with it, out_tag carries the tag presented in that cycle.
- R3: When prot_en is 0 the access never faults and out_bypass is 1.
- R4: When prot_en is 1 and both long_act and cs_long are 1, the access never faults and out_bypass is 1; if either of those two bits is 0, the access is checked and out_bypass is 0.
- R5: A checked access with is_write=1 to a segment with seg_wr=0 faults.
- R6: A checked access with is_write=0 and is_exec=0 to a segment with seg_rd=0 faults; a fetch (is_exec=1) is not blocked by seg_rd=0.
- R7: For a checked access with seg_down=0 and limit >= base, the access faults exactly when limit < offset + size.
- R8: For a checked access with seg_down=0 and limit < base, the access faults exactly when limit < offset + size and offset < base.
- R9: For a checked access with seg_down=1 and limit < base, the access faults exactly when offset <= limit or offset + size >= base.
- R10: For a checked access with seg_down=1 and limit >= base, the access faults exactly when offset <= limit and offset + size >= base.
- R11: offset + size is evaluated with one extra bit, so an access near the top of the address space does not wrap.
- R12: out_addr carries the offset of the access reported in the same cycle.
- R13: When out_valid is 0, out_fault and out_bypass are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An access is presented this cycle |
| in_tag | input | TW | Caller tag, echoed with the result |
| offset | input | AW | Effective offset of the access |
| acc_size | input | SW | Access length in bytes |
| is_write | input | 1 | Access is a write |
| is_exec | input | 1 | Access is an instruction fetch |
| seg_base | input | AW | Segment base |
| seg_limit | input | AW | Segment limit |
| seg_wr | input | 1 | Segment writable |
| seg_rd | input | 1 | Segment readable |
| seg_down | input | 1 | Segment grows downward |
| prot_en | input | 1 | Protection enabled |
| long_act | input | 1 | Long mode active |
| cs_long | input | 1 | Code segment is 64-bit |
| out_valid | output | 1 | Result valid |
| out_tag | output | TW | Echoed tag |
| out_fault | output | 1 | General-protection fault |
| out_bypass | output | 1 | Access was not checked |
| out_addr | output | AW | Passed-through offset |

## Verification
Every result field appears exactly one clock after the access is presented. The bench drives each access just after a falling edge. At the next falling edge, after the single register stage has loaded, it compares outputs against the model's prediction for that access. Tag, offset, fault and bypass are compared only in cycles when the model expects a valid result. The valid flag is compared in every cycle, so idle gaps are checked for silence.

// File: rtl/seg_guard.sv
module seg_guard #(
  parameter int AW = 32,
  parameter int SW = 4,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [TW-1:0] in_tag,
  input  logic [AW-1:0] offset,
  input  logic [SW-1:0] acc_size,
  input  logic          is_write,
  input  logic          is_exec,
  input  logic [AW-1:0] seg_base,
  input  logic [AW-1:0] seg_limit,
  input  logic          seg_wr,
  input  logic          seg_rd,
  input  logic          seg_down,
  input  logic          prot_en,
  input  logic          long_act,
  input  logic          cs_long,
  output logic          out_valid,
  output logic [TW-1:0] out_tag,
  output logic          out_fault,
  output logic          out_bypass,
  output logic [AW-1:0] out_addr
);
  localparam int XW = AW + 1;

  logic [XW-1:0] lo_x, end_x, base_x, lim_x;
  logic checked, wrapped, up_fault, dn_fault, right_fault, gp;

  assign lo_x   = {1'b0, offset};
  assign end_x  = lo_x + XW'(acc_size);
  assign base_x = {1'b0, seg_base};
  assign lim_x  = {1'b0, seg_limit};

  assign checked = prot_en & ~(long_act & cs_long);
  assign wrapped = lim_x < base_x;

  assign up_fault = wrapped ? ((lim_x < end_x) && (lo_x < base_x))
                            : (lim_x < end_x);
  assign dn_fault = wrapped ? ((lo_x <= lim_x) || (end_x >= base_x))
                            : ((lo_x <= lim_x) && (end_x >= base_x));

  assign right_fault = (is_write & ~seg_wr) | (~is_write & ~is_exec & ~seg_rd);
  assign gp = checked & (right_fault | (seg_down ? dn_fault : up_fault));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_fault  <= 1'b0;
      out_bypass <= 1'b0;
      out_tag    <= '0;
      out_addr   <= '0;
    end else begin
      out_valid  <= in_valid;
      out_fault  <= in_valid & gp;
      out_bypass <= in_valid & ~checked;
      if (in_valid) begin
        out_tag  <= in_tag;
        out_addr <= offset;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  tag_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_tag == $past(in_tag)));
  // R12
  addr_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_addr == $past(offset)));
  // R3
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_bypass |-> !out_fault);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_fault && !out_bypass));
  // R5
  write_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && prot_en && !(long_act && cs_long) && is_write && !seg_wr) |=> out_fault);
  // R3
  real_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !prot_en) |=> (out_bypass && !out_fault));
endmodule

// File: tb/seg_guard_test.sv
`timescale 1ns/1ps
module seg_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  in_tag = '0;
  logic [31:0] offset = '0;
  logic [3:0]  acc_size = '0;
  logic        is_write = 1'b0, is_exec = 1'b0;
  logic [31:0] seg_base = '0, seg_limit = '0;
  logic        seg_wr = 1'b0, seg_rd = 1'b0, seg_down = 1'b0;
  logic        prot_en = 1'b0, long_act = 1'b0, cs_long = 1'b0;
  logic        out_valid, out_fault, out_bypass;
  logic [3:0]  out_tag;
  logic [31:0] out_addr;

  int vectors = 0;
  int misses  = 0;

  bit          exp_v = 0, exp_f = 0, exp_b = 0;
  logic [3:0]  exp_tag = '0;
  logic [31:0] exp_addr = '0;
  string       exp_req = "R1";

  always #2.5 clk = ~clk;

  seg_guard uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .offset(offset), .acc_size(acc_size), .is_write(is_write), .is_exec(is_exec),
    .seg_base(seg_base), .seg_limit(seg_limit), .seg_wr(seg_wr), .seg_rd(seg_rd),
    .seg_down(seg_down), .prot_en(prot_en), .long_act(long_act), .cs_long(cs_long),
    .out_valid(out_valid), .out_tag(out_tag), .out_fault(out_fault),
    .out_bypass(out_bypass), .out_addr(out_addr)
  );

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input longint off, input int sz, input bit w, input bit x,
                                input longint b, input longint l, input bit wr, input bit rd,
                                input bit dn, input bit pe, input bit lma, input bit csl,
                                output bit f, output bit byp, output string req);
    longint e;
    e = off + sz;
    f = 0; byp = 0;
    if (!pe) begin byp = 1; req = "R3"; end
    else if (lma && csl) begin byp = 1; req = "R4"; end
    else if (w && !wr) begin f = 1; req = "R5"; end
    else if (!w && !x && !rd) begin f = 1; req = "R6"; end
    else if (!dn) begin
      if (l >= b) begin req = "R7"; f = (l < e); end
      else begin req = "R8"; f = (l < e) && (off < b); end
    end else begin
      if (l < b) begin req = "R9"; f = (off <= l) || (e >= b); end
      else begin req = "R10"; f = (off <= l) && (e >= b); end
    end
  endfunction

  task automatic compare_now();
    check("R2 valid", out_valid, exp_v);
    if (exp_v) begin
      check({exp_req, " fault"}, out_fault, exp_f);
      check({exp_req, " bypass"}, out_bypass, exp_b);
      check("R2 tag", out_tag, exp_tag);
      check("R12 addr", out_addr, exp_addr);
    end else begin
      check("R13 fault idle", out_fault, 0);
    end
  endtask

  task automatic step(input bit v, input logic [3:0] tg, input longint off, input int sz,
                      input bit w, input bit x, input longint b, input longint l,
                      input bit wr, input bit rd, input bit dn,
                      input bit pe, input bit lma, input bit csl);
    bit f, byp;
    string req;
    @(negedge clk);
    compare_now();
    in_valid = v; in_tag = tg; offset = off[31:0]; acc_size = sz[3:0];
    is_write = w; is_exec = x; seg_base = b[31:0]; seg_limit = l[31:0];
    seg_wr = wr; seg_rd = rd; seg_down = dn; prot_en = pe; long_act = lma; cs_long = csl;
    model(off, sz, w, x, b, l, wr, rd, dn, pe, lma, csl, f, byp, req);
    exp_v = v; exp_f = f; exp_b = byp; exp_req = req;
    if (v) begin exp_tag = tg; exp_addr = off[31:0]; end
  endtask

  initial begin
    #(5.0 * 100000);
    misses++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", out_valid, 0);
    check("R1 fault in reset", out_fault, 0);
    rst_n = 1'b1;
    // R3 real mode: write to read-only, out of limit, still passes
    step(1, 4'h1, 64'h5000, 4, 1, 0, 0, 64'h10, 0, 0, 0, 0, 0, 0);
    // R4 64-bit mode bypass, and partial long bits still checked
    step(1, 4'h2, 64'h5000, 4, 1, 0, 0, 64'h10, 0, 0, 0, 1, 1, 1);
    step(1, 4'h3, 64'h5000, 4, 0, 0, 0, 64'h10, 1, 1, 0, 1, 1, 0);
    step(1, 4'h4, 64'h5000, 4, 0, 0, 0, 64'h10, 1, 1, 0, 1, 0, 1);
    // R5 write to non-writable; R6 read from non-readable, fetch allowed
    step(1, 4'h5, 64'h10, 4, 1, 0, 0, 64'hFFF, 0, 1, 0, 1, 0, 0);
    step(1, 4'h6, 64'h10, 4, 0, 0, 0, 64'hFFF, 1, 0, 0, 1, 0, 0);
    step(1, 4'h7, 64'h10, 4, 0, 1, 0, 64'hFFF, 0, 0, 0, 1, 0, 0);
    step(0, 4'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R7 boundary
    step(1, 4'h8, 64'hFFC, 4, 0, 0, 0, 64'hFFF, 1, 1, 0, 1, 0, 0);
    step(1, 4'h9, 64'hFFC, 3, 0, 0, 0, 64'hFFF, 1, 1, 0, 1, 0, 0);
    // R8 limit below base
    step(1, 4'hA, 64'h900, 4, 0, 0, 64'h1000, 64'h800, 1, 1, 0, 1, 0, 0);
    step(1, 4'hB, 64'h100, 4, 0, 0, 64'h1000, 64'h800, 1, 1, 0, 1, 0, 0);
    step(1, 4'hC, 64'h2000, 4, 0, 0, 64'h1000, 64'h800, 1, 1, 0, 1, 0, 0);
    // R9 grows down, limit below base
    step(1, 4'hD, 64'h90, 4, 0, 0, 64'h100, 64'h80, 1, 1, 1, 1, 0, 0);
    step(1, 4'hE, 64'h80, 4, 0, 0, 64'h100, 64'h80, 1, 1, 1, 1, 0, 0);
    step(1, 4'hF, 64'hFE, 2, 0, 0, 64'h100, 64'h80, 1, 1, 1, 1, 0, 0);
    // R10 grows down, limit above base
    step(1, 4'h1, 64'h50, 4, 0, 0, 64'h100, 64'h200, 1, 1, 1, 1, 0, 0);
    step(1, 4'h2, 64'h150, 4, 0, 0, 64'h100, 64'h200, 1, 1, 1, 1, 0, 0);
    step(1, 4'h3, 64'h300, 4, 0, 0, 64'h100, 64'h200, 1, 1, 1, 1, 0, 0);
    // R11 top of address space must not wrap
    step(1, 4'h4, 64'hFFFFFFFC, 8, 0, 0, 0, 64'hFFFFFFFF, 1, 1, 0, 1, 0, 0);
    step(1, 4'h5, 64'hFFFFFFF0, 8, 0, 0, 0, 64'hFFFFFFFF, 1, 1, 0, 1, 0, 0);
    for (int i = 0; i < 400; i++) begin
      longint pick[4];
      longint b, l, o;
      pick[0] = 64'h0; pick[1] = 64'h100; pick[2] = 64'h1000; pick[3] = 64'hFFFFFF00;
      b = pick[$urandom_range(0, 3)];
      l = pick[$urandom_range(0, 3)] + $urandom_range(0, 3) - 2;
      if (l < 0) l = 0;
      o = pick[$urandom_range(0, 3)] + $urandom_range(0, 8) - 4;
      if (o < 0) o = 0;
      if (o > 64'hFFFFFFFF) o = 64'hFFFFFFFF;
      if (l > 64'hFFFFFFFF) l = 64'hFFFFFFFF;
      step($urandom_range(0, 7) != 0, 4'($urandom), o, $urandom_range(1, 8),
           $urandom_range(0, 1), $urandom_range(0, 1), b, l,
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1),
           $urandom_range(0, 7) != 0, $urandom_range(0, 1), $urandom_range(0, 1));
    end
    step(0, 4'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    @(negedge clk);
    compare_now();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule